// File: doc/BRIEF.md
# Total-Store-Order Store Buffer with Load Forwarding

This block sits between one in-order core and a single-ported shared memory. It gives that core total-store-order behaviour. Stores from the core are accepted into a small in-order queue and retire at once on the core side. They are then written to memory one at a time, oldest first, in the background. A later load to a different word need not wait for those writes. A load to a word that still has a queued store takes its value from the youngest such store and never reaches memory. A fence holds the core until every earlier store has reached memory. This gives the core a way to restore store-then-load ordering when it needs it.

The core issues one request at a time over a valid/ready handshake, using an operation code, a word address and write data. Loads and fences complete with a single-cycle response pulse. Stores complete when they are accepted. On the memory side there is one request channel with its own valid/ready handshake, and a single response strobe that serves both writes and reads. Only one memory transaction is outstanding at a time.

Top module: `tsb_store_buffer`

## Requirements
- R1: Accepted stores are written to memory exactly once each and strictly in acceptance order. Two stores to the same address are never merged; both writes appear on the memory port.
- R2: A store (op code 1) is accepted while fewer than DEPTH (default 4) stores are queued. With DEPTH stores queued, req_ready_o stays low for a store until a queued write completes.
- R3: A load (op code 0) whose address equals one or more queued stores returns the data of the most recently accepted of those stores. rsp_valid_o is high in the cycle after acceptance, and no memory read is issued.
- R4: A load that matches no queued store reads memory and returns the memory data. rsp_valid_o rises in the cycle after the memory response strobe. The load may complete while stores to other addresses are still queued.
- R5: After a load or fence is accepted, req_ready_o stays low until its rsp_valid_o pulse. rsp_valid_o is never raised without such an outstanding request.
- R6: A fence (op code 2 or 3) is answered only when no store is queued and no write is in flight. No request is accepted between the fence and its answer.
- R7: The block never presents a memory request while an earlier memory transaction still waits for its response.
- R8: When a queued write and a pending load read both need the free memory port, the write goes first. The exception is when the transaction that just completed was itself a write; then the load goes.
- R9: While mem_req_valid_o is high and mem_req_ready_i is low, the request stays asserted with unchanged write-enable, address and write data.
- R10: Driving rst_ni low empties the queue, returns the pointers to entry 0, and drops any pending load or fence. Queued stores are then never written. Afterwards req_ready_o is high and mem_req_valid_o and rsp_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Core request accepted this cycle when high with valid |
| req_op_i | input | 2 | 0 load, 1 store, 2 or 3 fence |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Store data |
| rsp_valid_o | output | 1 | Load or fence completion pulse |
| rsp_data_o | output | DW | Load data (zero for a fence) |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_we_o | output | 1 | 1 write (drain), 0 read (load) |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rsp_valid_i | input | 1 | Memory completion strobe for the outstanding transaction |
| mem_rdata_i | input | DW | Memory read data, valid with the strobe |

## Verification
The per-cycle assertions cover the port-level rules: the single outstanding memory transaction, the held request payload, the store stall at full occupancy, the core stall while a load or fence is pending, a fence answered only with nothing queued or in flight, and the write-first port priority. The values themselves can only be judged by the bench's scenarios. These are the youngest-match forwarding result, the memory data returned on a miss, the oldest-first write order including repeated addresses, and the queued stores that reset discards.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2
  } core_op_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_LOAD_MEM = 2'd1,
    ST_FENCE    = 2'd2
  } ctl_state_e;

  typedef enum logic {
    PORT_DRAIN = 1'b0,
    PORT_LOAD  = 1'b1
  } port_kind_e;
endpackage

// File: rtl/tsb_fifo.sv
module tsb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [AW-1:0]              push_addr_i,
  input  logic [DW-1:0]              push_data_i,
  input  logic                       pop_i,
  output logic                       full_o,
  output logic                       empty_o,
  output logic [AW-1:0]              head_addr_o,
  output logic [DW-1:0]              head_data_o,
  output logic [PW-1:0]              tail_o,
  output logic [DEPTH-1:0]           vld_o,
  output logic [DEPTH-1:0][AW-1:0]   addr_o,
  output logic [DEPTH-1:0][DW-1:0]   data_o
);
  logic [PW-1:0]             head_q, tail_q;
  logic [CW-1:0]             cnt_q;
  logic [DEPTH-1:0]          vld_q;
  logic [DEPTH-1:0][AW-1:0]  addr_q;
  logic [DEPTH-1:0][DW-1:0]  data_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= bump(tail_q);
      if (pop_i)  head_q <= bump(head_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end

  // occupancy flags per slot, used by the forward search
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_i && tail_q == PW'(i))     vld_q[i] <= 1'b1;
        else if (pop_i && head_q == PW'(i)) vld_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && tail_q == PW'(i)) begin
        addr_q[i] <= push_addr_i;
        data_q[i] <= push_data_i;
      end
    end
  end

  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];
  assign tail_o      = tail_q;
  assign vld_o       = vld_q;
  assign addr_o      = addr_q;
  assign data_o      = data_q;
endmodule

// File: rtl/tsb_fwd_search.sv
module tsb_fwd_search #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]          vld_i,
  input  logic [DEPTH-1:0][AW-1:0]  addr_i,
  input  logic [DEPTH-1:0][DW-1:0]  data_i,
  input  logic [PW-1:0]             tail_i,
  input  logic [AW-1:0]             lookup_addr_i,
  output logic                      hit_o,
  output logic [DW-1:0]             data_o
);
  logic [DEPTH-1:0] match;
  logic [PW-1:0]    idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld_i[i] && (addr_i[i] == lookup_addr_i);
  end

  // walk from the newest slot (tail-1) back toward the oldest; first match wins
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    idx    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = PW'((int'(tail_i) + 2 * DEPTH - 1 - k) % DEPTH);
      if (!hit_o && match[idx]) begin
        hit_o  = 1'b1;
        data_o = data_i[idx];
      end
    end
  end
endmodule

// File: rtl/tsb_mem_port.sv
module tsb_mem_port
  import tsb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drain_want_i,
  input  logic [AW-1:0] drain_addr_i,
  input  logic [DW-1:0] drain_data_i,
  input  logic          load_want_i,
  input  logic [AW-1:0] load_addr_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_rsp_valid_i,
  output logic          drain_done_o,
  output logic          load_done_o
);
  logic       busy_q, last_drain_q, hold_q;
  port_kind_e kind_q, hold_kind_q, sel_kind;
  logic       pick_load, issue, done;

  assign pick_load = load_want_i && (!drain_want_i || last_drain_q);
  // once offered, the choice is frozen until the handshake
  assign sel_kind  = hold_q ? hold_kind_q : (pick_load ? PORT_LOAD : PORT_DRAIN);

  assign mem_req_valid_o = !busy_q && (hold_q || drain_want_i || load_want_i);
  assign mem_we_o        = (sel_kind == PORT_DRAIN);
  assign mem_addr_o      = (sel_kind == PORT_DRAIN) ? drain_addr_i : load_addr_i;
  assign mem_wdata_o     = (sel_kind == PORT_DRAIN) ? drain_data_i : '0;

  assign issue        = mem_req_valid_o && mem_req_ready_i;
  assign done         = busy_q && mem_rsp_valid_i;
  assign drain_done_o = done && (kind_q == PORT_DRAIN);
  assign load_done_o  = done && (kind_q == PORT_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      kind_q       <= PORT_DRAIN;
      last_drain_q <= 1'b0;
      hold_q       <= 1'b0;
      hold_kind_q  <= PORT_DRAIN;
    end else begin
      if (issue) begin
        busy_q <= 1'b1;
        kind_q <= sel_kind;
        hold_q <= 1'b0;
      end else if (mem_req_valid_o) begin
        hold_q      <= 1'b1;
        hold_kind_q <= sel_kind;
      end
      if (done) begin
        busy_q       <= 1'b0;
        last_drain_q <= (kind_q == PORT_DRAIN);
      end
    end
  end
endmodule

// File: rtl/tsb_store_buffer.sv
module tsb_store_buffer
  import tsb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctl_state_e               st_q;
  logic [AW-1:0]            ld_addr_q;
  logic                     rsp_valid_q;
  logic [DW-1:0]            rsp_data_q;

  logic                     full, empty, push, pop, accept;
  logic                     is_store, is_load, is_fence;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;
  logic [PW-1:0]            tail;
  logic [DEPTH-1:0]         vld;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic                     fwd_hit;
  logic [DW-1:0]            fwd_data;
  logic                     load_done;

  assign is_store = (req_op_i == OP_STORE);
  assign is_load  = (req_op_i == OP_LOAD);
  assign is_fence = req_op_i[1];

  assign req_ready_o = (st_q == ST_IDLE) && !(is_store && full);
  assign accept      = req_valid_i && req_ready_o;
  assign push        = accept && is_store;

  tsb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_wdata_i),
    .pop_i       (pop),
    .full_o      (full),
    .empty_o     (empty),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .tail_o      (tail),
    .vld_o       (vld),
    .addr_o      (ent_addr),
    .data_o      (ent_data)
  );

  tsb_fwd_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .vld_i         (vld),
    .addr_i        (ent_addr),
    .data_i        (ent_data),
    .tail_i        (tail),
    .lookup_addr_i (req_addr_i),
    .hit_o         (fwd_hit),
    .data_o        (fwd_data)
  );

  tsb_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .drain_want_i    (!empty),
    .drain_addr_i    (head_addr),
    .drain_data_i    (head_data),
    .load_want_i     (st_q == ST_LOAD_MEM),
    .load_addr_i     (ld_addr_q),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .drain_done_o    (pop),
    .load_done_o     (load_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ld_addr_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept && is_load) begin
            if (fwd_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= fwd_data;
            end else begin
              st_q      <= ST_LOAD_MEM;
              ld_addr_q <= req_addr_i;
            end
          end else if (accept && is_fence) begin
            st_q <= ST_FENCE;
          end
        end
        ST_LOAD_MEM: begin
          if (load_done) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= mem_rdata_i;
            st_q        <= ST_IDLE;
          end
        end
        ST_FENCE: begin
          // pop happens on write completion, so empty implies nothing in flight
          if (empty) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= '0;
            st_q        <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/tsb_store_buffer_chk.sv
module tsb_store_buffer_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [1:0]    req_op_i,
  input logic          rsp_valid_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_rsp_valid_i
);
  int   occ_q;
  logic inflight_q, inflight_we_q, outstanding_q, fence_out_q, last_write_q;
  logic acc, st_acc, wr_done;

  assign acc     = req_valid_i && req_ready_o;
  assign st_acc  = acc && (req_op_i == 2'd1);
  assign wr_done = inflight_q && mem_rsp_valid_i && inflight_we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q         <= 0;
      inflight_q    <= 1'b0;
      inflight_we_q <= 1'b0;
      outstanding_q <= 1'b0;
      fence_out_q   <= 1'b0;
      last_write_q  <= 1'b0;
    end else begin
      occ_q <= occ_q + (st_acc ? 1 : 0) - (wr_done ? 1 : 0);
      if (mem_req_valid_o && mem_req_ready_i) begin
        inflight_q    <= 1'b1;
        inflight_we_q <= mem_we_o;
      end else if (inflight_q && mem_rsp_valid_i) begin
        inflight_q   <= 1'b0;
        last_write_q <= inflight_we_q;
      end
      if (rsp_valid_o) begin
        outstanding_q <= 1'b0;
        fence_out_q   <= 1'b0;
      end
      if (acc && req_op_i != 2'd1) begin
        outstanding_q <= 1'b1;
        fence_out_q   <= req_op_i[1];
      end
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !inflight_q); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R9
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == DEPTH) |-> !st_acc); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= DEPTH); // R2
  AST_WRITE_HAS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_we_o |-> occ_q != 0); // R1
  AST_CORE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_q && !rsp_valid_o |-> !req_ready_o); // R5
  AST_RSP_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> outstanding_q); // R5
  AST_FENCE_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && fence_out_q |-> occ_q == 0 && !inflight_q); // R6
  AST_DRAIN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_we_o && occ_q != 0 |-> last_write_q); // R8
endmodule

bind tsb_store_buffer tsb_store_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_op_i        (req_op_i),
  .rsp_valid_o     (rsp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_wdata_o     (mem_wdata_o),
  .mem_rsp_valid_i (mem_rsp_valid_i)
);

// File: tb/tsb_store_buffer_tb.sv
module tsb_store_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [1:0]    req_op_i = 2'd0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          rsp_valid_o;
  logic [DW-1:0] rsp_data_o;
  logic          mem_req_valid_o;
  logic          mem_req_ready_i = 1'b0;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_rsp_valid_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tsb_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_op_i(req_op_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rdata_i(mem_rdata_i)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [DW-1:0] bmem [256];
  int            q_addr [$];
  logic [DW-1:0] q_data [$];
  bit  stall_mem = 1'b0;
  bit  mm_busy = 1'b0, mm_commit = 1'b0, mm_we = 1'b0;
  int  mm_lat = 0, mm_addr = 0, rd_count = 0, rd_rsp_cyc = -10;
  logic [DW-1:0] mm_data = '0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_word(input int a);
    return 32'hA500_0000 | a;
  endfunction

  // memory model: handshake decided at negedge, response strobe one or more cycles later
  always @(negedge clk) begin
    if (!rst_ni) begin
      mm_busy = 1'b0; mm_commit = 1'b0;
      mem_rsp_valid_i = 1'b0; mem_req_ready_i = 1'b0;
      q_addr.delete(); q_data.delete();
    end else begin
      bit was_busy;
      was_busy = mm_busy;
      mem_rsp_valid_i = 1'b0;
      if (mm_commit) begin
        bmem[mm_addr] = mm_data;
        void'(q_addr.pop_front());
        void'(q_data.pop_front());
        mm_commit = 1'b0;
      end
      if (mm_busy) begin
        mm_lat--;
        if (mm_lat == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rdata_i = mm_we ? '0 : bmem[mm_addr];
          mm_busy = 1'b0;
          mm_commit = mm_we;
          if (!mm_we) rd_rsp_cyc = cyc;
        end
      end
      mem_req_ready_i = !stall_mem && ($urandom_range(9) < 7);
      if (mem_req_valid_o && mem_req_ready_i) begin
        check(!was_busy, "R7 second request while busy", 32'(mem_addr_o), 32'hFFFF_FFFF);
        if (mem_we_o) begin
          // R1: oldest queued store, each exactly once
          check(q_addr.size() > 0 && int'(mem_addr_o) == q_addr[0] && mem_wdata_o == q_data[0],
                "R1 write order", mem_wdata_o, (q_data.size() > 0) ? q_data[0] : '0);
        end else begin
          rd_count++;
        end
        mm_busy = 1'b1;
        mm_we = mem_we_o;
        mm_addr = int'(mem_addr_o);
        mm_data = mem_wdata_o;
        mm_lat = 1 + $urandom_range(2);
      end
    end
  end

  task automatic offer(input logic [1:0] op, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = AW'(a); req_wdata_i = d;
    #1;
    while (!req_ready_o) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic finish_offer();
    @(posedge clk);
    #1;
    req_valid_i = 1'b0;
  endtask

  task automatic do_store(input int a, input logic [DW-1:0] d);
    offer(2'd1, a, d);
    q_addr.push_back(a);
    q_data.push_back(d);
    finish_offer();
  endtask

  task automatic do_load(input int a, output int nbuf);
    bit hit;
    logic [DW-1:0] exp;
    int rc;
    offer(2'd0, a, '0);
    hit = 1'b0;
    exp = bmem[a];
    for (int i = q_addr.size() - 1; i >= 0; i--) begin
      if (!hit && q_addr[i] == a) begin
        hit = 1'b1;
        exp = q_data[i];
      end
    end
    rc = rd_count;
    finish_offer();
    @(negedge clk);
    if (hit) begin
      check(rsp_valid_o == 1'b1, "R3 forward latency", 32'(rsp_valid_o), 32'd1);
      check(rsp_data_o == exp, "R3 youngest match data", rsp_data_o, exp);
      check(rd_count == rc, "R3 no memory read", 32'(rd_count), 32'(rc));
    end else begin
      while (!rsp_valid_o) begin
        check(!req_ready_o, "R5 ready low during load", 32'(req_ready_o), 32'd0);
        @(negedge clk);
      end
      check(rsp_data_o == exp, "R4 memory data", rsp_data_o, exp);
      check(rd_rsp_cyc == cyc - 1, "R4 response latency", 32'(rd_rsp_cyc), 32'(cyc - 1));
    end
    nbuf = q_addr.size();
  endtask

  task automatic do_fence();
    offer(2'd2, 0, '0);
    finish_offer();
    @(negedge clk);
    while (!rsp_valid_o) begin
      check(!req_ready_o, "R6 ready low during fence", 32'(req_ready_o), 32'd0);
      @(negedge clk);
    end
    check(q_addr.size() == 0 && !mm_busy, "R6 fence after drain", 32'(q_addr.size()), 32'd0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int nb;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) bmem[i] = init_word(i);

    // R10: reset state
    repeat (3) @(negedge clk);
    check(req_ready_o && !mem_req_valid_o && !rsp_valid_o, "R10 reset outputs",
          {29'd0, req_ready_o, mem_req_valid_o, rsp_valid_o}, 32'd4);
    rst_ni = 1'b1;

    // R3 / R1: repeated address, youngest wins, both writes kept
    stall_mem = 1'b1;
    do_store(50, 32'h1111);
    do_store(51, 32'h2222);
    do_store(50, 32'h3333);
    do_load(50, nb);
    do_load(51, nb);
    stall_mem = 1'b0;
    do_fence();
    check(bmem[50] == 32'h3333, "R1 last write to repeated address", bmem[50], 32'h3333);

    // R2: full buffer stalls a store; R9: held request payload
    stall_mem = 1'b1;
    for (int i = 0; i < DEPTH; i++) do_store(20 + i, 32'h2000 + i);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = 2'd1; req_addr_i = AW'(24); req_wdata_i = 32'h2004;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(!req_ready_o, "R2 store held when full", 32'(req_ready_o), 32'd0);
      check(mem_req_valid_o && mem_we_o && mem_addr_o == AW'(20), "R9 held request",
            32'(mem_addr_o), 32'd20);
      @(negedge clk);
    end
    req_valid_i = 1'b0;
    stall_mem = 1'b0;
    do_store(24, 32'h2004);
    do_fence();
    check(bmem[24] == 32'h2004, "R2 stalled store written", bmem[24], 32'h2004);

    // R4 / R8: miss completes with stores still queued
    stall_mem = 1'b1;
    do_store(30, 32'h30);
    do_store(31, 32'h31);
    do_store(32, 32'h32);
    fork
      begin
        repeat (4) @(negedge clk);
        stall_mem = 1'b0;
      end
    join_none
    do_load(40, nb);
    check(nb > 0, "R4 R8 load passes queued stores", 32'(nb), 32'd1);
    do_fence();

    // R10: reset discards queued stores
    stall_mem = 1'b1;
    do_store(60, 32'h6060);
    do_store(61, 32'h6161);
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(req_ready_o && !mem_req_valid_o && !rsp_valid_o, "R10 outputs in reset",
          {29'd0, req_ready_o, mem_req_valid_o, rsp_valid_o}, 32'd4);
    rst_ni = 1'b1;
    stall_mem = 1'b0;
    do_load(60, nb);
    check(bmem[60] == init_word(60), "R10 discarded store never written", bmem[60],
          init_word(60));

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r, a;
      r = $urandom_range(9);
      a = $urandom_range(7);
      if (r < 5) do_store(a, $urandom);
      else if (r < 9) do_load(a, nb);
      else do_fence();
    end
    do_fence();

    summary();
    $finish;
  end
endmodule